// File: doc/BRIEF.md
# Multiplexed ADC Conversion Sequencer

This block sits between an 8-bit host register port and an eight-input, single-ended, 12-bit analog-to-digital converter. It frames every conversion as a run of eight pacer ticks and then fires a one-cycle start strobe to the converter. The ticks either run freely in pacer mode, or a host write to the start offset lets a single burst of eight through in software mode. The block also picks the input channel, either fixed from the control register or stepped by auto-scan.

When the converter signals done, the 12-bit result is held in a latch. The host collects it as two byte reads from one offset, low byte first. While a result waits, an active-low ready bit in the status register is 0 and the interrupt request is high. In auto-scan mode the channel moves on when the host reads the high byte, not when the conversion ends. A result that arrives before the previous one has been fully read replaces it and sets an overrun bit.

Top module: `adc_seq_top`

## Requirements
- R1: The control register at offset 0 reads back the last byte written. Bit 0 (sw_mode) selects software start when 1. Bit 1 (auto_scan) selects scanning when 1. Bits 6:4 hold a channel code k that selects input k+1, and mux_sel shows k. Bit 7 is stored but has no effect on mux_sel.
- R2: With bit 0 low, adc_start pulses for one cycle on the cycle after every 8th pacer tick. The count restarts from zero on any control write.
- R3: With bit 0 high, pacer ticks alone never start a conversion. A write to offset 5 arms a burst, adc_start pulses once after the 8th following tick, and further ticks give no more starts.
- R4: adc_done latches adc_data. From the next cycle, status bit 0 (ready_n) reads 0 and irq is 1.
- R5: Reads of offset 6 return data[7:0] first and then {0000, data[11:8]}. After the second read, ready_n is 1 and irq is 0.
- R6: Each newly latched result resets the byte order, so the next offset-6 read returns its low byte.
- R7: In auto-scan mode mux_sel starts at the code written to the control register. It steps by one on each high-byte read and does not change when a conversion completes.
- R8: Auto-scan wraps from code 7 (channel 8) to code 0 (channel 1).
- R9: A done that arrives while ready_n is 0 overwrites the latch and sets status bit 1 (overrun). A read of the status register at offset 7 clears that bit.
- R10: In manual mode, result reads never move mux_sel.
- R11: After reset the control register reads 0x00, status reads 0x01, mux_sel is 0, and irq and adc_start are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle; read side effects occur at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pacer_tick | input | 1 | One-cycle pacer tick |
| adc_start | output | 1 | One-cycle conversion start strobe |
| adc_done | input | 1 | Converter completion strobe |
| adc_data | input | 12 | Converter result, valid with adc_done |
| mux_sel | output | 3 | Input channel code, 0 selects channel 1 |
| irq | output | 1 | Interrupt request, high while a result is unread |

## Verification
The bench counts ticks one at a time. A framer that is off by one in either direction would start on the 7th or 9th tick, or would keep starting in software mode after its burst. It checks that the scan channel stays put across a completed conversion and moves only on the high-byte read; a design that advanced on completion or on the low byte would show the wrong mux_sel. It drives a second result between the two byte reads of the first. A design that kept the old byte pointer would hand back the new high byte first, and one without overrun tracking would leave status bit 1 clear. It also passes through the 7-to-0 wrap and checks that bit 7 of the control register cannot reach the channel code.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int BUS_W          = 8;
    localparam int DATA_W         = 12;
    localparam int CH_W           = 3;
    localparam int TICKS_PER_CONV = 8;

    localparam logic [2:0] OFS_CTRL  = 3'd0;
    localparam logic [2:0] OFS_START = 3'd5;
    localparam logic [2:0] OFS_DATA  = 3'd6;
    localparam logic [2:0] OFS_STAT  = 3'd7;

    typedef struct packed {
        logic            rsvd;
        logic [CH_W-1:0] chan;
        logic [1:0]      spare;
        logic            auto_scan;
        logic            sw_mode;
    } ctrl_t;

    function automatic logic [BUS_W-1:0] pack_status(input logic overrun, input logic ready);
        logic [BUS_W-1:0] s;
        s    = '0;
        s[1] = overrun;
        s[0] = ~ready;
        return s;
    endfunction
endpackage

// File: rtl/adc_tick_framer.sv
module adc_tick_framer #(
    parameter int TICKS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic sw_mode,
    input  logic clear,
    input  logic go,
    input  logic tick,
    output logic start
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt;
    logic          armed;
    logic          counting;

    assign counting = !sw_mode || armed;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt   <= '0;
            armed <= 1'b0;
            start <= 1'b0;
        end else begin
            start <= 1'b0;
            if (go && sw_mode) begin
                armed <= 1'b1;
                cnt   <= '0;
            end else if (tick && counting) begin
                if (cnt == LAST) begin
                    cnt   <= '0;
                    start <= 1'b1;
                    if (sw_mode) armed <= 1'b0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/adc_result_latch.sv
module adc_result_latch #(
    parameter int DATA_W = 12,
    parameter int BUS_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  logic [DATA_W-1:0] data,
    input  logic              rd_data,
    input  logic              rd_status,
    output logic [BUS_W-1:0]  lo_byte,
    output logic [BUS_W-1:0]  hi_byte,
    output logic              byte_hi,
    output logic              ready,
    output logic              overrun,
    output logic              hi_read
);
    localparam int HI_W = DATA_W - BUS_W;

    logic [DATA_W-1:0] res;

    assign lo_byte = res[BUS_W-1:0];
    assign hi_byte = {{(BUS_W-HI_W){1'b0}}, res[DATA_W-1:BUS_W]};
    assign hi_read = rd_data && byte_hi && !done;

    always_ff @(posedge clk) begin
        if (rst) begin
            res     <= '0;
            byte_hi <= 1'b0;
            ready   <= 1'b0;
            overrun <= 1'b0;
        end else if (done) begin
            res     <= data;
            byte_hi <= 1'b0;
            ready   <= 1'b1;
            overrun <= overrun || ready;
        end else begin
            if (rd_data) begin
                byte_hi <= ~byte_hi;
                if (byte_hi) ready <= 1'b0;
            end
            if (rd_status) overrun <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_chan_sel.sv
module adc_chan_sel #(
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [CH_W-1:0] load_code,
    input  logic            auto_scan,
    input  logic [CH_W-1:0] manual_code,
    input  logic            advance,
    output logic [CH_W-1:0] sel
);
    logic [CH_W-1:0] scan_q;

    always_ff @(posedge clk) begin
        if (rst)                        scan_q <= '0;
        else if (load)                  scan_q <= load_code;
        else if (advance && auto_scan)  scan_q <= scan_q + 1'b1;
    end

    assign sel = auto_scan ? scan_q : manual_code;
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              pacer_tick,
    output logic              adc_start,
    input  logic              adc_done,
    input  logic [DATA_W-1:0] adc_data,
    output logic [CH_W-1:0]   mux_sel,
    output logic              irq
);
    ctrl_t ctrl_q;
    ctrl_t ctrl_new;

    logic ctrl_wr, start_wr, data_rd, stat_rd;
    logic [BUS_W-1:0] lo_byte, hi_byte;
    logic byte_hi, ready, overrun, hi_read;

    assign ctrl_new = ctrl_t'(bus_wdata);
    assign ctrl_wr  = bus_wr && (bus_addr == OFS_CTRL);
    assign start_wr = bus_wr && (bus_addr == OFS_START);
    assign data_rd  = bus_rd && (bus_addr == OFS_DATA);
    assign stat_rd  = bus_rd && (bus_addr == OFS_STAT);

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= ctrl_new;
    end

    adc_tick_framer #(.TICKS(TICKS_PER_CONV)) u_framer (
        .clk     (clk),
        .rst     (rst),
        .sw_mode (ctrl_q.sw_mode),
        .clear   (ctrl_wr),
        .go      (start_wr),
        .tick    (pacer_tick),
        .start   (adc_start)
    );

    adc_result_latch #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .done      (adc_done),
        .data      (adc_data),
        .rd_data   (data_rd),
        .rd_status (stat_rd),
        .lo_byte   (lo_byte),
        .hi_byte   (hi_byte),
        .byte_hi   (byte_hi),
        .ready     (ready),
        .overrun   (overrun),
        .hi_read   (hi_read)
    );

    adc_chan_sel #(.CH_W(CH_W)) u_chan (
        .clk         (clk),
        .rst         (rst),
        .load        (ctrl_wr),
        .load_code   (ctrl_new.chan),
        .auto_scan   (ctrl_q.auto_scan),
        .manual_code (ctrl_q.chan),
        .advance     (hi_read),
        .sel         (mux_sel)
    );

    assign irq = ready;

    always_comb begin
        case (bus_addr)
            OFS_CTRL: bus_rdata = ctrl_q;
            OFS_DATA: bus_rdata = byte_hi ? hi_byte : lo_byte;
            OFS_STAT: bus_rdata = pack_status(overrun, ready);
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] bus_addr,
    input logic       bus_wr,
    input logic [7:0] bus_rdata,
    input logic       pacer_tick,
    input logic       adc_start,
    input logic       adc_done,
    input logic [2:0] mux_sel,
    input logic       irq,
    input logic       auto_scan,
    input logic       byte_hi,
    input logic       hi_read
);
    logic ctrl_wr;
    assign ctrl_wr = bus_wr && (bus_addr == 3'd0);

    AST_START_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        adc_start |-> $past(pacer_tick)); // R2

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        adc_start |=> !adc_start); // R3

    AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
        adc_done |=> irq); // R4

    AST_HI_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 3'd6 && byte_hi) |-> (bus_rdata[7:4] == 4'h0)); // R5

    AST_MANUAL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!auto_scan && !ctrl_wr) |=> $stable(mux_sel)); // R10

    AST_SCAN_WRAP: assert property (@(posedge clk) disable iff (rst)
        (auto_scan && hi_read && mux_sel == 3'd7 && !ctrl_wr) |=> (mux_sel == 3'd0)); // R8
endmodule

bind adc_seq_top adc_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rdata  (bus_rdata),
    .pacer_tick (pacer_tick),
    .adc_start  (adc_start),
    .adc_done   (adc_done),
    .mux_sel    (mux_sel),
    .irq        (irq),
    .auto_scan  (ctrl_q.auto_scan),
    .byte_hi    (byte_hi),
    .hi_read    (hi_read)
);

// File: tb/tb_adc_seq_top.sv
`timescale 1ns/1ps
module tb_adc_seq_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        pacer_tick = 1'b0;
    logic        adc_start;
    logic        adc_done = 1'b0;
    logic [11:0] adc_data = '0;
    logic [2:0]  mux_sel;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    adc_seq_top dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pacer_tick(pacer_tick),
        .adc_start(adc_start), .adc_done(adc_done), .adc_data(adc_data),
        .mux_sel(mux_sel), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic tick(output logic st);
        @(negedge clk); pacer_tick = 1'b1;
        @(negedge clk); pacer_tick = 1'b0;
        st = adc_start;
    endtask

    task automatic finish_conv(input logic [11:0] d);
        @(negedge clk); adc_done = 1'b1; adc_data = d;
        @(negedge clk); adc_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R11 start", adc_start, 0);
        check("R11 irq", irq, 0);
        check("R11 mux", mux_sel, 0);
        rd(3'd0, d); check("R11 ctrl", d, 8'h00);
        rd(3'd7, d); check("R11 status", d, 8'h01);
    endtask

    task automatic t_pacer();
        logic st;
        int n, first;
        logic [7:0] d;
        wr(3'd0, 8'h20);
        check("R1 mux code 2", mux_sel, 2);
        rd(3'd0, d); check("R1 readback", d, 8'h20);
        n = 0; first = -1;
        for (int i = 1; i <= 16; i++) begin
            tick(st);
            if (st) begin n++; if (first < 0) first = i; end
        end
        check("R2 starts in 16 ticks", n, 2);
        check("R2 first start tick", first, 8);
    endtask

    task automatic t_convert();
        logic [7:0] d;
        finish_conv(12'hA5C);
        check("R4 irq", irq, 1);
        rd(3'd7, d); check("R4 ready_n low", d, 8'h00);
        rd(3'd6, d); check("R5 low byte", d, 8'h5C);
        check("R5 irq after low", irq, 1);
        rd(3'd6, d); check("R5 high byte", d, 8'h0A);
        check("R5 irq cleared", irq, 0);
        rd(3'd7, d); check("R5 ready_n high", d, 8'h01);
    endtask

    task automatic t_software();
        logic st;
        int n, first;
        wr(3'd0, 8'h01);
        n = 0;
        for (int i = 0; i < 12; i++) begin tick(st); if (st) n++; end
        check("R3 no start without write", n, 0);
        wr(3'd5, 8'h00);
        n = 0; first = -1;
        for (int i = 1; i <= 16; i++) begin
            tick(st);
            if (st) begin n++; if (first < 0) first = i; end
        end
        check("R3 single burst start", n, 1);
        check("R3 start on 8th tick", first, 8);
    endtask

    task automatic t_scan();
        logic [7:0] d;
        wr(3'd0, 8'h62);
        check("R7 initial code", mux_sel, 6);
        finish_conv(12'h111);
        check("R7 no move on done", mux_sel, 6);
        rd(3'd6, d); check("R7 no move on low", mux_sel, 6);
        rd(3'd6, d); check("R7 step on high", mux_sel, 7);
        finish_conv(12'h222);
        rd(3'd6, d); rd(3'd6, d);
        check("R8 wrap to 0", mux_sel, 0);
        wr(3'd0, 8'h30);
        finish_conv(12'h333);
        rd(3'd6, d); rd(3'd6, d);
        check("R10 manual hold", mux_sel, 3);
        wr(3'd0, 8'hB0);
        check("R1 bit7 ignored", mux_sel, 3);
        rd(3'd0, d); check("R1 bit7 stored", d, 8'hB0);
    endtask

    task automatic t_overrun();
        logic [7:0] d;
        wr(3'd0, 8'h00);
        finish_conv(12'h123);
        rd(3'd6, d); check("R5 low before overrun", d, 8'h23);
        finish_conv(12'h456);
        rd(3'd7, d); check("R9 overrun set", d, 8'h02);
        rd(3'd7, d); check("R9 overrun cleared", d, 8'h00);
        rd(3'd6, d); check("R6 low byte of new", d, 8'h56);
        rd(3'd6, d); check("R6 high byte of new", d, 8'h04);
        rd(3'd7, d); check("R9 idle status", d, 8'h01);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_pacer();
        t_convert();
        t_software();
        t_scan();
        t_overrun();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule